// File: doc/BRIEF.md
# Parallel-Port Boot Command Sequencer

This block sits on the host side of a 16-bit register and socket port belonging to an attached USB peripheral. When `start` is pulsed it runs a fixed bring-up dialogue with the device through a simple register master. The master has an address, a write flag, 16-bit write and read data, a request strobe and a done return. The dialogue has six stages. It confirms the device identity and the two mailbox signatures. It programs the initialisation, configuration, socket-mask and interrupt-mask registers. It waits for the outbound socket and arms a transmit transfer. It streams a 512-byte framed command packet to port address 0. It arms a receive transfer and confirms its size. It then reads the 512-byte response from port address 2.

The sequence ends with a one-cycle `done` pulse. With it come a pass flag, an error code naming the first check that failed, and the status byte from the response. Every poll loop is bounded by a programmable count of unsuccessful reads. Bytes are packed little-endian into 16-bit words: an even byte goes in bits 7:0 and the following odd byte in bits 15:8.

States, in order: IDLE, RD_ID, RD_MB2, RD_MB3, WR_INIT, WR_CFG, WR_MSKH, WR_MSKL, WR_IMSK, POLL_S0, ARM_TX, POLL_TX, SEND, POLL_S2, ARM_RX, POLL_RX, RD_SIZE, RECV, DONE. Each state moves to the next one in this list when `bus_done` arrives and its check holds. The exceptions are these:
- IDLE waits for `start`. A rejected length goes straight to DONE.
- A poll state stays put on a not-ready read. It leaves for DONE when the read limit is reached.
- SEND and RECV advance only on their last word.
- Any failed check goes to DONE.
- DONE always returns to IDLE.

Top module: `ppboot_seq`

## Requirements
- R1: After reset `busy`, `done` and `bus_req` are 0, `pass` is 0 and `err_code` is 0.
- R2: Once raised, `bus_req` stays high with stable `bus_addr`, `bus_we` and `bus_wdata` until `bus_done`. Each `bus_done` completes exactly one access.
- R3: The first reads are register 0x83, which must return 0x0081, then 0x9C and 0x9D, which must return 0x5943 and 0x4257. A wrong identity ends with `err_code` 1. A wrong mailbox ends with `err_code` 2. In both cases no write is issued.
- R4: Setup writes go out in this order: 0x81←0x0000, 0x82←0x0040, 0x8B←0x0000, 0x8A←0x0007, 0x88←0x2001.
- R5: Before sending, register 0x9E is read until bit 0 is 1. Then 0x8E←0x0300 is written, and 0x8E is read until bits 12 and 15 are both 1. A read with only bit 12 set does not advance.
- R6: The command packet is 256 writes to port address 0, laid out as follows:
  - word 0 is 0x5943;
  - word 1 is {length, code};
  - for code 0x01, word 2 is address[15:0] and word 3 is address[31:16]; for other codes both are 0;
  - all later words are 0.
- R7: After sending, 0x9E is read until bit 2 is 1 (bit 0 is ignored here). Then 0x8E←0x0102 is written, and 0x8E is read until bit 12 is 1. Register 0x8F must then read 0x0200, otherwise `err_code` is 4 and port address 2 is never read.
- R8: The response is 256 reads of port address 2. Word 0 must be 0x4257, otherwise `err_code` is 5. `status_byte` is bits 15:8 of word 1, and bits 7:0 are ignored. A nonzero status gives `err_code` 6.
- R9: A start with code 0x02 and a length above 16 (`MAX_BLOCKS`) gives `done` on the next cycle with `err_code` 7 and no bus access. A length of 16 is accepted.
- R10: If `tmo_limit` consecutive reads in one poll loop find the device not ready, the run ends with `err_code` 3 after exactly that many reads.
- R11: `done` is a one-cycle pulse. `pass` is 1 exactly when `err_code` is 0. Results hold until the next start. `busy` is high from the cycle after `start` through `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (sampled while idle) |
| cmd_code | input | 8 | Command code placed in packet byte 2 |
| cmd_len | input | 8 | Length/status byte placed in packet byte 3 |
| cmd_addr | input | 32 | Target address for the memory-write command |
| tmo_limit | input | TMO_W | Not-ready reads allowed per poll loop (at least 1) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Last sequence succeeded |
| err_code | output | 4 | Error of last sequence (0 none) |
| status_byte | output | 8 | Status byte from the response |
| bus_req | output | 1 | Access request, held until done |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Register or port address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with bus_done |
| bus_done | input | 1 | One-cycle access completion |

## Verification
The assertions take three things for granted about the inputs:
- `bus_done` is only returned while `bus_req` is high, and as a single-cycle pulse.
- `start` is meaningful only while the block is idle.
- `tmo_limit` is at least 1.

The bench's device model only counts latency while a request is open. It drops `bus_done` the cycle after raising it. It starts a new access only after that gap. The bench pulses `start` only after `done` has been seen, and always programs a nonzero limit.

// File: rtl/ppboot_pkg.sv
package ppboot_pkg;

    localparam int DW = 16;

    localparam logic [7:0] REG_IDENT   = 8'h83;
    localparam logic [7:0] REG_MBOX_A  = 8'h9C;
    localparam logic [7:0] REG_MBOX_B  = 8'h9D;
    localparam logic [7:0] REG_INIT    = 8'h81;
    localparam logic [7:0] REG_CFG     = 8'h82;
    localparam logic [7:0] REG_SMASK_H = 8'h8B;
    localparam logic [7:0] REG_SMASK_L = 8'h8A;
    localparam logic [7:0] REG_IMASK   = 8'h88;
    localparam logic [7:0] REG_SOCKST  = 8'h9E;
    localparam logic [7:0] REG_XFER    = 8'h8E;
    localparam logic [7:0] REG_XSIZE   = 8'h8F;
    localparam logic [7:0] PORT_TX     = 8'h00;
    localparam logic [7:0] PORT_RX     = 8'h02;

    localparam logic [15:0] IDENT_VAL  = 16'h0081;
    localparam logic [15:0] MBOX_A_VAL = 16'h5943;
    localparam logic [15:0] MBOX_B_VAL = 16'h4257;
    localparam logic [15:0] CFG_VAL    = 16'h0040;
    localparam logic [15:0] SMASK_L_V  = 16'h0007;
    localparam logic [15:0] IMASK_VAL  = 16'h2001;
    localparam logic [15:0] XFER_TX    = 16'h0300;
    localparam logic [15:0] XFER_RX    = 16'h0102;
    localparam logic [15:0] XSIZE_VAL  = 16'h0200;

    localparam logic [7:0] CMD_SYNC0  = 8'h43;
    localparam logic [7:0] CMD_SYNC1  = 8'h59;
    localparam logic [7:0] RSP_SYNC0  = 8'h57;
    localparam logic [7:0] RSP_SYNC1  = 8'h42;
    localparam logic [7:0] CODE_MEMWR = 8'h01;
    localparam logic [7:0] CODE_BOOT  = 8'h02;

    typedef enum logic [4:0] {
        S_IDLE, S_RD_ID, S_RD_MB2, S_RD_MB3,
        S_WR_INIT, S_WR_CFG, S_WR_MSKH, S_WR_MSKL, S_WR_IMSK,
        S_POLL_S0, S_ARM_TX, S_POLL_TX, S_SEND,
        S_POLL_S2, S_ARM_RX, S_POLL_RX, S_RD_SIZE, S_RECV,
        S_DONE
    } seq_state_t;

    typedef enum logic [3:0] {
        E_NONE    = 4'd0,
        E_IDENT   = 4'd1,
        E_MBOX    = 4'd2,
        E_TIMEOUT = 4'd3,
        E_SIZE    = 4'd4,
        E_SIG     = 4'd5,
        E_STATUS  = 4'd6,
        E_LEN     = 4'd7
    } seq_err_t;

endpackage

// File: rtl/ppboot_wait_timer.sv
module ppboot_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic [W:0]   cnt_nx;

    assign cnt_nx = {1'b0, cnt_q} + 1'b1;
    // R10: the read that brings the miss count to the limit ends the loop
    assign expire = inc && (cnt_nx >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (inc)    cnt_q <= cnt_nx[W-1:0];
    end
endmodule

// File: rtl/ppboot_pkt_word.sv
module ppboot_pkt_word
    import ppboot_pkg::*;
#(
    parameter int IW = 8
) (
    input  logic [IW-1:0] idx,
    input  logic [7:0]    code,
    input  logic [7:0]    len,
    input  logic [31:0]   addr,
    output logic [DW-1:0] word
);
    // R6: little-endian byte packing, even byte in the low half
    always_comb begin
        word = '0;
        if (idx == IW'(0))
            word = {CMD_SYNC1, CMD_SYNC0};
        else if (idx == IW'(1))
            word = {len, code};
        else if (idx == IW'(2) && code == CODE_MEMWR)
            word = addr[15:0];
        else if (idx == IW'(3) && code == CODE_MEMWR)
            word = addr[31:16];
    end
endmodule

// File: rtl/ppboot_seq.sv
module ppboot_seq
    import ppboot_pkg::*;
#(
    parameter int AW         = 8,
    parameter int PKT_BYTES  = 512,
    parameter int TMO_W      = 16,
    parameter int MAX_BLOCKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       cmd_code,
    input  logic [7:0]       cmd_len,
    input  logic [31:0]      cmd_addr,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic [3:0]       err_code,
    output logic [7:0]       status_byte,
    output logic             bus_req,
    output logic             bus_we,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_done
);
    localparam int WORDS = PKT_BYTES / 2;
    localparam int IW    = $clog2(WORDS);

    seq_state_t state_q, state_d;
    seq_err_t   err_d, err_q;

    logic [IW-1:0] idx_q;
    logic [7:0]    code_q, len_q, status_q;
    logic [31:0]   addr_q;
    logic          pass_q, sig_ok_q;
    logic          last_word, len_bad;
    logic          poll_st, poll_ok, tmo_hit;
    logic [DW-1:0] pkt_word;

    assign last_word = (idx_q == IW'(WORDS - 1));
    assign len_bad   = (cmd_code == CODE_BOOT) && (cmd_len > 8'(MAX_BLOCKS));

    ppboot_pkt_word #(.IW(IW)) u_pkt (
        .idx  (idx_q),
        .code (code_q),
        .len  (len_q),
        .addr (addr_q),
        .word (pkt_word)
    );

    ppboot_wait_timer #(.W(TMO_W)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!poll_st),
        .inc    (poll_st && bus_done && !poll_ok),
        .limit  (tmo_limit),
        .expire (tmo_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        err_d   = E_NONE;
        unique case (state_q)
            S_IDLE:
                if (start) begin
                    if (len_bad) begin state_d = S_DONE; err_d = E_LEN; end
                    else state_d = S_RD_ID;
                end
            S_RD_ID:
                if (bus_done) begin
                    if (bus_rdata == IDENT_VAL) state_d = S_RD_MB2;
                    else begin state_d = S_DONE; err_d = E_IDENT; end
                end
            S_RD_MB2:
                if (bus_done) begin
                    if (bus_rdata == MBOX_A_VAL) state_d = S_RD_MB3;
                    else begin state_d = S_DONE; err_d = E_MBOX; end
                end
            S_RD_MB3:
                if (bus_done) begin
                    if (bus_rdata == MBOX_B_VAL) state_d = S_WR_INIT;
                    else begin state_d = S_DONE; err_d = E_MBOX; end
                end
            S_WR_INIT: if (bus_done) state_d = S_WR_CFG;
            S_WR_CFG:  if (bus_done) state_d = S_WR_MSKH;
            S_WR_MSKH: if (bus_done) state_d = S_WR_MSKL;
            S_WR_MSKL: if (bus_done) state_d = S_WR_IMSK;
            S_WR_IMSK: if (bus_done) state_d = S_POLL_S0;
            S_POLL_S0, S_POLL_TX, S_POLL_S2, S_POLL_RX:
                if (bus_done) begin
                    if (poll_ok) begin
                        unique case (state_q)
                            S_POLL_S0: state_d = S_ARM_TX;
                            S_POLL_TX: state_d = S_SEND;
                            S_POLL_S2: state_d = S_ARM_RX;
                            default:   state_d = S_RD_SIZE;
                        endcase
                    end else if (tmo_hit) begin
                        state_d = S_DONE;
                        err_d   = E_TIMEOUT;
                    end
                end
            S_ARM_TX: if (bus_done) state_d = S_POLL_TX;
            S_SEND:   if (bus_done && last_word) state_d = S_POLL_S2;
            S_ARM_RX: if (bus_done) state_d = S_POLL_RX;
            S_RD_SIZE:
                if (bus_done) begin
                    if (bus_rdata == XSIZE_VAL) state_d = S_RECV;
                    else begin state_d = S_DONE; err_d = E_SIZE; end
                end
            S_RECV:
                if (bus_done && last_word) begin
                    state_d = S_DONE;
                    if (!sig_ok_q)           err_d = E_SIG;
                    else if (status_q != 0)  err_d = E_STATUS;
                end
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        poll_st   = 1'b0;
        poll_ok   = 1'b0;
        unique case (state_q)
            S_RD_ID:   begin bus_req = 1'b1; bus_addr = AW'(REG_IDENT);  end
            S_RD_MB2:  begin bus_req = 1'b1; bus_addr = AW'(REG_MBOX_A); end
            S_RD_MB3:  begin bus_req = 1'b1; bus_addr = AW'(REG_MBOX_B); end
            S_WR_INIT: begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(REG_INIT); end
            S_WR_CFG:  begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(REG_CFG); bus_wdata = CFG_VAL; end
            S_WR_MSKH: begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(REG_SMASK_H); end
            S_WR_MSKL: begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(REG_SMASK_L); bus_wdata = SMASK_L_V; end
            S_WR_IMSK: begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(REG_IMASK); bus_wdata = IMASK_VAL; end
            S_POLL_S0: begin bus_req = 1'b1; bus_addr = AW'(REG_SOCKST); poll_st = 1'b1; poll_ok = bus_rdata[0]; end
            S_ARM_TX:  begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(REG_XFER); bus_wdata = XFER_TX; end
            S_POLL_TX: begin bus_req = 1'b1; bus_addr = AW'(REG_XFER); poll_st = 1'b1; poll_ok = bus_rdata[12] && bus_rdata[15]; end
            S_SEND:    begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(PORT_TX); bus_wdata = pkt_word; end
            S_POLL_S2: begin bus_req = 1'b1; bus_addr = AW'(REG_SOCKST); poll_st = 1'b1; poll_ok = bus_rdata[2]; end
            S_ARM_RX:  begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(REG_XFER); bus_wdata = XFER_RX; end
            S_POLL_RX: begin bus_req = 1'b1; bus_addr = AW'(REG_XFER); poll_st = 1'b1; poll_ok = bus_rdata[12]; end
            S_RD_SIZE: begin bus_req = 1'b1; bus_addr = AW'(REG_XSIZE); end
            S_RECV:    begin bus_req = 1'b1; bus_addr = AW'(PORT_RX); end
            default:   ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            code_q   <= '0;
            len_q    <= '0;
            addr_q   <= '0;
            status_q <= '0;
            sig_ok_q <= 1'b0;
            pass_q   <= 1'b0;
            err_q    <= E_NONE;
        end else begin
            if (state_q == S_IDLE && start) begin
                code_q   <= cmd_code;
                len_q    <= cmd_len;
                addr_q   <= cmd_addr;
                status_q <= '0;
                sig_ok_q <= 1'b0;
                pass_q   <= 1'b0;
                err_q    <= E_NONE;
            end
            if (state_q != S_SEND && state_q != S_RECV)
                idx_q <= '0;
            else if (bus_done)
                idx_q <= idx_q + 1'b1;
            if (state_q == S_RECV && bus_done) begin
                if (idx_q == IW'(0)) sig_ok_q <= (bus_rdata == {RSP_SYNC1, RSP_SYNC0});
                if (idx_q == IW'(1)) status_q <= bus_rdata[15:8];
            end
            if (state_d == S_DONE && state_q != S_DONE) begin
                err_q  <= err_d;
                pass_q <= (err_d == E_NONE);
            end
        end
    end

    assign busy        = (state_q != S_IDLE);
    assign done        = (state_q == S_DONE);
    assign pass        = pass_q;
    assign err_code    = err_q;
    assign status_byte = status_q;

endmodule

// File: rtl/ppboot_seq_chk.sv
module ppboot_seq_chk #(
    parameter int AW         = 8,
    parameter int MAX_BLOCKS = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [7:0]    cmd_code,
    input logic [7:0]    cmd_len,
    input logic          busy,
    input logic          done,
    input logic          pass,
    input logic [3:0]    err_code,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [15:0]   bus_wdata,
    input logic          bus_done
);
    // R2: an open access keeps its request fields until completed
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    // R9: oversize enter-boot length is rejected in the next cycle
    a_r9_len_reject: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && cmd_code == 8'h02 && cmd_len > 8'(MAX_BLOCKS) |=> done && err_code == 4'd7 && !bus_req);

    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: pass agrees with an empty error code
    a_r11_pass_err: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass == (err_code == 4'd0)));

    // R1: no bus activity while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    // R11: results stay frozen after completion until a new start
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(err_code) && $stable(pass));
endmodule

bind ppboot_seq ppboot_seq_chk #(.AW(AW), .MAX_BLOCKS(MAX_BLOCKS)) u_chk (.*);

// File: tb/sim_ppboot_seq.sv
`timescale 1ns/1ps
module sim_ppboot_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cmd_code = '0, cmd_len = '0;
    logic [31:0] cmd_addr = '0;
    logic [15:0] tmo_limit = 16'd50;
    logic        busy, done, pass;
    logic [3:0]  err_code;
    logic [7:0]  status_byte;
    logic        bus_req, bus_we;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_done = 1'b0;

    always #4 clk = ~clk;

    ppboot_seq u0 (.*);

    // device model configuration (driven by tasks only)
    logic        reload = 1'b0;
    logic [15:0] c_id, c_mb2, c_mb3, c_size, c_w0, c_w1;
    int          c_s0, c_xtx, c_s2, c_xrx;

    // device model state
    logic [15:0] pkt [256];
    logic [23:0] wlog [16];
    int pkt_n, wl_n, txn, sk_rd, xf_rd, rx_rd, s0_l, s2_l, xf_l, lat;
    logic rx_ph;

    always @(posedge clk) begin
        if (reload) begin
            pkt_n <= 0; wl_n <= 0; txn <= 0; sk_rd <= 0; xf_rd <= 0; rx_rd <= 0;
            s0_l <= c_s0; s2_l <= c_s2; xf_l <= c_xtx; rx_ph <= 1'b0;
            lat <= 0; bus_done <= 1'b0;
        end else if (bus_req && !bus_done) begin
            if (lat == 1) begin
                lat <= 0;
                bus_done <= 1'b1;
                txn <= txn + 1;
                if (bus_we) begin
                    if (bus_addr == 8'h00) begin
                        if (pkt_n < 256) pkt[pkt_n] <= bus_wdata;
                        pkt_n <= pkt_n + 1;
                        if (pkt_n == 255) begin rx_ph <= 1'b1; xf_l <= c_xrx; end
                    end else begin
                        if (wl_n < 16) wlog[wl_n] <= {bus_addr, bus_wdata};
                        wl_n <= wl_n + 1;
                    end
                end else begin
                    case (bus_addr)
                        8'h83: bus_rdata <= c_id;
                        8'h9C: bus_rdata <= c_mb2;
                        8'h9D: bus_rdata <= c_mb3;
                        8'h8F: bus_rdata <= c_size;
                        8'h9E: begin
                            sk_rd <= sk_rd + 1;
                            if (!rx_ph) begin
                                if (s0_l == 0) bus_rdata <= 16'h0001;
                                else begin bus_rdata <= 16'h0000; s0_l <= s0_l - 1; end
                            end else begin
                                if (s2_l == 0) bus_rdata <= 16'h0004;
                                else begin bus_rdata <= 16'h0001; s2_l <= s2_l - 1; end
                            end
                        end
                        8'h8E: begin
                            xf_rd <= xf_rd + 1;
                            if (!rx_ph) begin
                                if (xf_l == 0) bus_rdata <= 16'h9000;
                                else begin bus_rdata <= 16'h1000; xf_l <= xf_l - 1; end
                            end else begin
                                if (xf_l == 0) bus_rdata <= 16'h1000;
                                else begin bus_rdata <= 16'h0000; xf_l <= xf_l - 1; end
                            end
                        end
                        8'h02: begin
                            rx_rd <= rx_rd + 1;
                            bus_rdata <= (rx_rd == 0) ? c_w0 : (rx_rd == 1) ? c_w1 : 16'h0000;
                        end
                        default: bus_rdata <= 16'hDEAD;
                    endcase
                end
            end else lat <= lat + 1;
        end else begin
            bus_done <= 1'b0;
            lat <= 0;
        end
    end

    int total = 0, bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic dev_defaults();
        c_id = 16'h0081; c_mb2 = 16'h5943; c_mb3 = 16'h4257; c_size = 16'h0200;
        c_w0 = 16'h4257; c_w1 = 16'h00AA;
        c_s0 = 3; c_xtx = 2; c_s2 = 2; c_xrx = 1;
    endtask

    task automatic run(input logic [7:0] code, input logic [7:0] len,
                       input logic [31:0] addr, input logic [15:0] lim);
        @(negedge clk); reload = 1'b1;
        @(negedge clk); reload = 1'b0;
        cmd_code = code; cmd_len = len; cmd_addr = addr; tmo_limit = lim; start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if (done) break;
            @(negedge clk);
        end
        chk("R11 done seen", {31'd0, done}, 32'd1);
    endtask

    task automatic t_reset();
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 done", {31'd0, done}, 0);
        chk("R1 bus_req", {31'd0, bus_req}, 0);
        chk("R1 pass", {31'd0, pass}, 0);
        chk("R1 err", {28'd0, err_code}, 0);
    endtask

    task automatic t_memwr();
        dev_defaults();
        run(8'h01, 8'h7E, 32'h40003000, 16'd50);
        chk("R11 pass", {31'd0, pass}, 1);
        chk("R11 err", {28'd0, err_code}, 0);
        chk("R8 status (low byte ignored)", {24'd0, status_byte}, 0);
        chk("R6 word count", pkt_n, 256);
        chk("R6 word0", {16'd0, pkt[0]}, 32'h5943);
        chk("R6 word1", {16'd0, pkt[1]}, 32'h7E01);
        chk("R6 word2", {16'd0, pkt[2]}, 32'h3000);
        chk("R6 word3", {16'd0, pkt[3]}, 32'h4000);
        chk("R6 word4", {16'd0, pkt[4]}, 0);
        chk("R6 word255", {16'd0, pkt[255]}, 0);
        chk("R4 write count", wl_n, 7);
        chk("R4 init", {8'd0, wlog[0]}, 32'h810000);
        chk("R4 cfg", {8'd0, wlog[1]}, 32'h820040);
        chk("R4 maskh", {8'd0, wlog[2]}, 32'h8B0000);
        chk("R4 maskl", {8'd0, wlog[3]}, 32'h8A0007);
        chk("R4 imask", {8'd0, wlog[4]}, 32'h882001);
        chk("R5 arm tx", {8'd0, wlog[5]}, 32'h8E0300);
        chk("R7 arm rx", {8'd0, wlog[6]}, 32'h8E0102);
        chk("R5 R7 socket polls", sk_rd, 4 + 3);
        chk("R5 R7 xfer polls (both bits needed)", xf_rd, 3 + 2);
        chk("R8 response reads", rx_rd, 256);
        @(negedge clk);
        chk("R11 busy drops", {31'd0, busy}, 0);
        chk("R11 pass held", {31'd0, pass}, 1);
        chk("R2 no stray access", txn, 3 + 7 + 7 + 5 + 1 + 256 + 256);
    endtask

    task automatic t_boot16();
        dev_defaults();
        run(8'h02, 8'd16, 32'hFFFF_FFFF, 16'd50);
        chk("R9 len 16 accepted", {28'd0, err_code}, 0);
        chk("R6 boot word1", {16'd0, pkt[1]}, 32'h1002);
        chk("R6 boot word2 no addr", {16'd0, pkt[2]}, 0);
        chk("R6 boot word3 no addr", {16'd0, pkt[3]}, 0);
    endtask

    task automatic t_bad_id();
        dev_defaults(); c_id = 16'h0080;
        run(8'h01, 8'h00, 32'h0, 16'd50);
        chk("R3 ident err", {28'd0, err_code}, 1);
        chk("R3 no writes", wl_n, 0);
        chk("R11 pass low", {31'd0, pass}, 0);
    endtask

    task automatic t_bad_mbox();
        dev_defaults(); c_mb3 = 16'h4253;
        run(8'h01, 8'h00, 32'h0, 16'd50);
        chk("R3 mailbox err", {28'd0, err_code}, 2);
        chk("R3 mailbox no writes", wl_n, 0);
    endtask

    task automatic t_bad_size();
        dev_defaults(); c_size = 16'h0100;
        run(8'h01, 8'h00, 32'h0, 16'd50);
        chk("R7 size err", {28'd0, err_code}, 4);
        chk("R7 no rx reads", rx_rd, 0);
    endtask

    task automatic t_bad_sig();
        dev_defaults(); c_w0 = 16'h4253;
        run(8'h01, 8'h00, 32'h0, 16'd50);
        chk("R8 signature err", {28'd0, err_code}, 5);
    endtask

    task automatic t_bad_status();
        dev_defaults(); c_w1 = 16'h0500;
        run(8'h02, 8'h01, 32'h0, 16'd50);
        chk("R8 status err", {28'd0, err_code}, 6);
        chk("R8 status byte", {24'd0, status_byte}, 5);
        chk("R8 pass low", {31'd0, pass}, 0);
    endtask

    task automatic t_len_guard();
        dev_defaults();
        run(8'h02, 8'd17, 32'h0, 16'd50);
        chk("R9 len err", {28'd0, err_code}, 7);
        chk("R9 no bus access", txn, 0);
    endtask

    task automatic t_timeout();
        dev_defaults(); c_s0 = 1000;
        run(8'h01, 8'h00, 32'h0, 16'd5);
        chk("R10 timeout err", {28'd0, err_code}, 3);
        chk("R10 poll reads", sk_rd, 5);
    endtask

    initial begin
        dev_defaults();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_memwr();
        t_boot16();
        t_bad_id();
        t_bad_mbox();
        t_bad_size();
        t_bad_sig();
        t_bad_status();
        t_len_guard();
        t_timeout();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end
endmodule